// File: doc/BRIEF.md
# Multi-Source Reset Controller with Boot Configuration Capture

This block turns four independent reset causes into one system reset. The causes are a dedicated power-on input, a bidirectional open-drain reset pin, a software request register, and a watchdog failure. Every reset is stretched to a guaranteed minimum width. While the device is in reset, the block pulls the shared reset pin low. That way the rest of the board sees the reset, and even a one-clock glitch on the pin produces a full-length reset.

While a power-on or pin reset is running, the block samples a small set of boot configuration pins. It freezes their value when the stretched reset ends. A software reset can instead install a boot value that software supplies, and this value is used for the start that follows. A watchdog failure first raises an NMI request and opens a grace window. If the watchdog is serviced inside that window, no reset happens.

Software reads a status word that holds the cause of the most recent reset and the boot value currently in force. It clears cause bits by writing ones to them.

Top module: `rstctl_top`

## Requirements
- R1: While `por_n` is low the block is held in reset asynchronously (`sys_rst_n` low, pin driven). After release, the status cause field reads 4'b0001 (bit 0 = power-on), and `boot_cfg` takes the value of `boot_pins`.
- R2: Each reset keeps `sys_rst_n` low for exactly MIN_W (16) cycles after the most recent trigger. A new trigger during a reset reloads the full width.
- R3: `rst_pin_oe` (drive the pin low) is high in exactly the cycles where `sys_rst_n` is low.
- R4: A low level on `rst_pin_i` lasting at least one clock edge causes a reset. `sys_rst_n` falls two cycles after that edge (synchronizer latency), and the cause field reads 4'b0010 (bit 1 = pin).
- R5: The block's own pin drive is never read back as an external reset. Once an internally caused reset ends, no further reset follows.
- R6: Writing address 1 with data bit 0 set starts a software reset in the next cycle, with cause 4'b0100 (bit 2). A write to address 1 with bit 0 clear has no effect on reset.
- R7: The boot value is captured from `boot_pins` in the final cycle of a power-on or pin reset. Pin changes during normal operation do not alter `boot_cfg`.
- R8: A software reset whose request word has bit 1 set loads `boot_cfg` from data bits [7:4] when that reset ends. With bit 1 clear, the previous boot value is kept. A watchdog reset also keeps it.
- R9: A watchdog failure pulse raises `wdt_nmi` in the next cycle. Unless `wdt_service` arrives first, a reset with cause 4'b1000 (bit 3) follows GRACE (8) cycles after the failure. A service pulse drops `wdt_nmi` and cancels the reset.
- R10: Reading address 0 returns {boot_cfg[3:0], cause[3:0]}, and the cause field is one-hot or zero. Writing address 0 clears the cause bits that are set in data bits [3:0] and leaves the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_i | input | 1 | Level read back from the shared reset pin |
| rst_pin_oe | output | 1 | Pull the shared reset pin low when high |
| boot_pins | input | 4 | Boot configuration pins |
| boot_cfg | output | 4 | Boot configuration in force |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| wdt_fail | input | 1 | Watchdog failure pulse |
| wdt_service | input | 1 | Watchdog service pulse |
| wdt_nmi | output | 1 | NMI request during watchdog grace window |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 reset request |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
A table of reset events drives pin pulses, software requests with and without a boot override, and watchdog expiries. These run in an order where the expected boot value depends on the reset before it, which separates keeping a boot value from replacing it. Each event checks its trigger latency, its stretch width and its recorded cause, so a wrong synchronizer depth, a wrong grace length or a swapped cause bit each show up separately. After every event the bench watches for a phantom second reset, which catches a broken readback blanking. Directed cases then cover a request word with the request bit clear, selective write-one-to-clear, a serviced watchdog, and a re-trigger in the middle of a reset that must lengthen it to 21 cycles.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    // Bit positions of the reset cause field in the status word
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_PIN = 1;
    localparam int CAUSE_SW  = 2;
    localparam int CAUSE_WDT = 3;
    localparam int CAUSE_W   = 4;

    // Register selects
    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_REQ    = 1'b1;

    // Where the boot value comes from when the running reset ends
    typedef enum logic [1:0] {
        SRC_KEEP = 2'd0,
        SRC_PINS = 2'd1,
        SRC_OVR  = 2'd2
    } boot_src_e;

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rstctl_wdt.sv
module rstctl_wdt #(
    parameter int GRACE = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic hold,
    input  logic fail,
    input  logic service,
    output logic nmi,
    output logic fire
);
    localparam int GW = $clog2(GRACE + 1);

    typedef struct packed {
        logic          alarm;
        logic [GW-1:0] cnt;
    } wdt_t;

    wdt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (hold || service) begin
            st_d.alarm = 1'b0;
            st_d.cnt   = '0;
        end else if (st_q.alarm) begin
            if (st_q.cnt == GW'(1)) begin
                fire       = 1'b1;
                st_d.alarm = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt - GW'(1);
            end
        end else if (fail) begin
            st_d.alarm = 1'b1;
            st_d.cnt   = GW'(GRACE);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{alarm: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end

    assign nmi = st_q.alarm;
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int MIN_W       = 16,
    parameter int GRACE       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BOOT_W      = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_i,
    output logic              rst_pin_oe,
    input  logic [BOOT_W-1:0] boot_pins,
    output logic [BOOT_W-1:0] boot_cfg,
    output logic              sys_rst_n,
    input  logic              wdt_fail,
    input  logic              wdt_service,
    output logic              wdt_nmi,
    input  logic              reg_wr_en,
    input  logic              reg_addr,
    input  logic [BOOT_W+3:0] reg_wdata,
    output logic [BOOT_W+3:0] reg_rdata
);
    localparam int CW = $clog2(MIN_W + 1);
    localparam int DW = BOOT_W + 4;

    typedef struct packed {
        logic [CW-1:0]          cnt;
        logic [CAUSE_W-1:0]     cause;
        logic [BOOT_W-1:0]      boot;
        boot_src_e              src;
        logic [BOOT_W-1:0]      ovr_val;
        logic                   ovr_en;
        logic [SYNC_STAGES-1:0] blank_hist;
    } core_t;

    core_t core_d, core_q;

    logic pin_s;
    logic in_rst;
    logic wdt_fire;
    logic blank;
    logic pin_req;
    logic sw_req;
    logic stat_wr;

    rstctl_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (rst_pin_i),
        .q     (pin_s)
    );

    rstctl_wdt #(.GRACE(GRACE)) u_wdt (
        .clk     (clk),
        .por_n   (por_n),
        .hold    (in_rst),
        .fail    (wdt_fail),
        .service (wdt_service),
        .nmi     (wdt_nmi),
        .fire    (wdt_fire)
    );

    assign in_rst = (core_q.cnt != '0);

    always_comb begin
        core_d = core_q;

        // Readback blanking: our own drive reaches pin_s up to SYNC_STAGES later
        blank   = in_rst | (|core_q.blank_hist);
        pin_req = ~pin_s & ~blank;
        sw_req  = reg_wr_en & (reg_addr == ADDR_REQ) & reg_wdata[0];
        stat_wr = reg_wr_en & (reg_addr == ADDR_STATUS);

        core_d.blank_hist = {core_q.blank_hist[SYNC_STAGES-2:0], in_rst};

        if (stat_wr) begin
            core_d.cause = core_q.cause & ~reg_wdata[CAUSE_W-1:0];
        end

        if (sw_req) begin
            core_d.ovr_val = reg_wdata[DW-1:4];
            core_d.ovr_en  = reg_wdata[1];
        end

        if (in_rst) begin
            core_d.cnt = core_q.cnt - CW'(1);
            if (core_q.cnt == CW'(1)) begin
                unique case (core_q.src)
                    SRC_PINS: core_d.boot = boot_pins;
                    SRC_OVR:  core_d.boot = core_q.ovr_val;
                    default:  core_d.boot = core_q.boot;
                endcase
            end
        end

        // Trigger priority: pin over watchdog over software
        if (pin_req) begin
            core_d.cnt              = CW'(MIN_W);
            core_d.cause            = '0;
            core_d.cause[CAUSE_PIN] = 1'b1;
            core_d.src              = SRC_PINS;
        end else if (wdt_fire) begin
            core_d.cnt              = CW'(MIN_W);
            core_d.cause            = '0;
            core_d.cause[CAUSE_WDT] = 1'b1;
            core_d.src              = SRC_KEEP;
        end else if (sw_req) begin
            core_d.cnt             = CW'(MIN_W);
            core_d.cause           = '0;
            core_d.cause[CAUSE_SW] = 1'b1;
            core_d.src             = reg_wdata[1] ? SRC_OVR : SRC_KEEP;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            core_q <= '{cnt:        CW'(MIN_W),
                        cause:      CAUSE_W'(1) << CAUSE_POR,
                        boot:       '0,
                        src:        SRC_PINS,
                        ovr_val:    '0,
                        ovr_en:     1'b0,
                        blank_hist: '1};
        end else begin
            core_q <= core_d;
        end
    end

    assign sys_rst_n  = ~in_rst;
    assign rst_pin_oe = in_rst;
    assign boot_cfg   = core_q.boot;

    always_comb begin
        if (reg_addr == ADDR_REQ) reg_rdata = {core_q.ovr_val, 2'b00, core_q.ovr_en, 1'b0};
        else                      reg_rdata = {core_q.boot, core_q.cause};
    end
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
    parameter int MIN_W  = 16,
    parameter int BOOT_W = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic              wdt_fail,
    input logic              wdt_service,
    input logic              wdt_nmi,
    input logic              reg_wr_en,
    input logic              reg_addr,
    input logic              req_bit,
    input logic [BOOT_W-1:0] boot_cfg,
    input logic [BOOT_W+3:0] reg_rdata
);
    localparam int LW = $clog2(MIN_W + 2);

    logic [LW-1:0] low_run_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 low_run_q <= '0;
        else if (sys_rst_n)         low_run_q <= '0;
        else if (low_run_q != '1)   low_run_q <= low_run_q + LW'(1);
    end

    // R2: a reset never ends before the minimum width
    a_r2_min_width: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> (low_run_q >= LW'(MIN_W)));

    // R6: a request write starts a reset
    a_r6_sw_trigger: assert property (@(posedge clk) disable iff (!por_n)
        (reg_wr_en && reg_addr && req_bit) |=> !sys_rst_n);

    // R7: boot value frozen outside reset
    a_r7_boot_stable: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst_n && $past(sys_rst_n)) |-> $stable(boot_cfg));

    // R9: failure raises NMI unless a reset intervenes
    a_r9_nmi_raise: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_fail && sys_rst_n && !wdt_nmi && !wdt_service) |=> (wdt_nmi || !sys_rst_n));

    // R9: service drops NMI
    a_r9_service_drops: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_service && wdt_nmi) |=> !wdt_nmi);

    // R10: cause field one-hot or clear
    a_r10_cause_onehot: assert property (@(posedge clk) disable iff (!por_n)
        !reg_addr |-> $onehot0(reg_rdata[3:0]));
endmodule

bind rstctl_top rstctl_chk #(.MIN_W(MIN_W), .BOOT_W(BOOT_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .wdt_fail    (wdt_fail),
    .wdt_service (wdt_service),
    .wdt_nmi     (wdt_nmi),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .req_bit     (reg_wdata[0]),
    .boot_cfg    (boot_cfg),
    .reg_rdata   (reg_rdata)
);

// File: tb/rstctl_top_bench.sv
`timescale 1ns/1ps
module rstctl_top_bench;
    localparam int MIN_W = 16;
    localparam int GRACE = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_drive = 1'b0;
    logic [3:0] boot_pins = 4'h5;
    logic       wdt_fail = 1'b0;
    logic       wdt_service = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       rst_pin_oe, sys_rst_n, wdt_nmi;
    logic [3:0] boot_cfg;
    logic [7:0] reg_rdata;
    logic       rst_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    // Open-drain pin with external pull-up
    assign rst_pin = ~(rst_pin_oe | ext_drive);

    rstctl_top u_rstctl_top (
        .clk(clk), .por_n(por_n), .rst_pin_i(rst_pin), .rst_pin_oe(rst_pin_oe),
        .boot_pins(boot_pins), .boot_cfg(boot_cfg), .sys_rst_n(sys_rst_n),
        .wdt_fail(wdt_fail), .wdt_service(wdt_service), .wdt_nmi(wdt_nmi),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [1:0] kind;   // 0 pin, 1 software, 2 watchdog
        logic       en;
        logic [3:0] pins;
        logic [3:0] val;
        logic [3:0] ecause;
        logic [3:0] eboot;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 1'b0, 4'hA, 4'h0, 4'b0010, 4'hA},
        '{2'd1, 1'b1, 4'hC, 4'h3, 4'b0100, 4'h3},
        '{2'd1, 1'b0, 4'hC, 4'h7, 4'b0100, 4'h3},
        '{2'd2, 1'b0, 4'h6, 4'h0, 4'b1000, 4'h3},
        '{2'd0, 1'b0, 4'h9, 4'h0, 4'b0010, 4'h9},
        '{2'd1, 1'b1, 4'h1, 4'hF, 4'b0100, 4'hF},
        '{2'd2, 1'b0, 4'h0, 4'h0, 4'b1000, 4'hF},
        '{2'd0, 1'b0, 4'h0, 4'h0, 4'b0010, 4'h0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic addr, input logic [7:0] data);
        reg_addr  = addr;
        reg_wdata = data;
        reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
        reg_addr  = 1'b0;
    endtask

    // Counts negedges with sys_rst_n low starting now; flags oe mismatches
    task automatic measure(output int width, output int oe_bad);
        width = 0; oe_bad = 0;
        while (sys_rst_n == 1'b0 && width < 200) begin
            if (rst_pin_oe !== 1'b1) oe_bad++;
            width++;
            tick();
        end
        if (rst_pin_oe !== 1'b0) oe_bad++;
    endtask

    task automatic quiet(input int n, output int lows);
        lows = 0;
        for (int k = 0; k < n; k++) begin
            tick();
            if (sys_rst_n !== 1'b1) lows++;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int w, ob, lat, lows;
        vec_t v;

        // R1 / R3: held by power-on
        tick(); tick(); tick();
        chk("R1 por holds sys_rst_n", sys_rst_n, 1'b0);
        chk("R3 pin driven during por", rst_pin_oe, 1'b1);
        por_n = 1'b1;
        measure(w, ob);
        chk("R2 por stretch width", w, MIN_W);
        chk("R3 oe tracks reset (por)", ob, 0);
        chk("R1 status after por", reg_rdata, 8'h51);
        chk("R1 boot latched from pins", boot_cfg, 4'h5);

        // R7: pins moving during normal operation
        boot_pins = 4'hE;
        quiet(5, lows);
        chk("R7 boot frozen", boot_cfg, 4'h5);

        // Reset event table
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            boot_pins = v.pins;
            tick();
            case (v.kind)
                2'd0: begin ext_drive = 1'b1; tick(); ext_drive = 1'b0; end
                2'd1: reg_write(1'b1, {v.val, 2'b00, v.en, 1'b1});
                default: begin wdt_fail = 1'b1; tick(); wdt_fail = 1'b0; end
            endcase
            lat = 0;
            while (sys_rst_n == 1'b1 && lat < 40) begin tick(); lat++; end
            chk(v.kind == 0 ? "R4 pin latency" : v.kind == 1 ? "R6 sw latency" : "R9 wdt latency",
                lat, v.kind == 0 ? 2 : v.kind == 1 ? 0 : GRACE);
            measure(w, ob);
            chk("R2 stretch width", w, MIN_W);
            chk("R3 oe tracks reset", ob, 0);
            quiet(6, lows);
            chk("R5 no self-triggered reset", lows, 0);
            chk("R10 status word", reg_rdata, {v.eboot, v.ecause});
            chk(v.kind == 1 ? "R8 boot after sw reset" : "R7 boot after reset", boot_cfg, v.eboot);
        end

        // R10: write-one-to-clear, selective
        reg_write(1'b0, 8'h04);
        chk("R10 unrelated bit kept", reg_rdata[3:0], 4'b0010);
        reg_write(1'b0, 8'h02);
        chk("R10 cause cleared", reg_rdata[3:0], 4'b0000);

        // R6: request word without the request bit
        reg_write(1'b1, 8'h52);
        quiet(6, lows);
        chk("R6 no reset without bit0", lows, 0);
        chk("R8 boot unchanged by idle write", boot_cfg, 4'h0);

        // R9: serviced watchdog
        wdt_fail = 1'b1; tick(); wdt_fail = 1'b0;
        chk("R9 nmi raised", wdt_nmi, 1'b1);
        tick(); tick(); tick();
        wdt_service = 1'b1; tick(); wdt_service = 1'b0;
        chk("R9 nmi dropped by service", wdt_nmi, 1'b0);
        quiet(GRACE + 4, lows);
        chk("R9 serviced watchdog no reset", lows, 0);

        // R2: re-trigger during reset extends it
        reg_write(1'b1, 8'h01);
        w = 0;
        while (sys_rst_n == 1'b0 && w < 200) begin
            w++;
            if (w == 5) begin
                reg_addr = 1'b1; reg_wdata = 8'h01; reg_wr_en = 1'b1;
            end else begin
                reg_wr_en = 1'b0; reg_addr = 1'b0;
            end
            tick();
        end
        reg_wr_en = 1'b0; reg_addr = 1'b0;
        chk("R2 reload extends width", w, 5 + MIN_W);
        chk("R6 cause after sw reset", reg_rdata[3:0], 4'b0100);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule